// File: doc/BRIEF.md
# Hash Message Block Loader

This block sits between a little-endian host bus and a hash compression core. The host writes 32-bit data words one at a time over a valid/ready handshake. Each accepted word passes through an endian converter before it is stored. A 2-bit data-type input selects the converter and tells the block how the host grouped the original bit string: as whole words, 16-bit halves, bytes or single bits. The result is the big-endian word order that the hash arithmetic expects.

The converted words are collected into a 512-bit message block of sixteen words. When the sixteenth word has been stored, the block raises block-valid and holds the block steady until the compression core acknowledges it. During that time the input stays closed. A synchronous clear throws away a partly gathered block, or a completed one, and restarts the count.

Top module: `hash_block_loader`

## Requirements
- R1: After reset, `blk_valid` is 0, `in_ready` is 1 and `blk_data` is all zeros.
- R2: With `dtype` = 2'b00 (word grouping), an accepted word is stored unchanged.
- R3: With `dtype` = 2'b01 (half-word grouping), the upper and lower 16-bit halves of the accepted word are exchanged.
- R4: With `dtype` = 2'b10 (byte grouping), the order of the four bytes of the accepted word is reversed.
- R5: With `dtype` = 2'b11 (bit grouping), the accepted word is mirrored, so bit i moves to bit 31-i.
- R6: The first accepted word of a block lands in `blk_data[511:480]` and the sixteenth lands in `blk_data[31:0]`. `blk_valid` rises on the clock edge that accepts the sixteenth word.
- R7: While `blk_valid` is 1, `in_ready` is 0, writes are ignored and `blk_data` stays stable. A cycle with `blk_ack` high drops `blk_valid` and raises `in_ready` at the next edge, and the next block starts again at word zero.
- R8: `dtype` is sampled with each accepted word, so the words of one block may use different swap modes. A cycle with `in_valid` low stores nothing.
- R9: `clr` high empties the block and zeroes the word count at the next edge, including a completed block. A write in the same cycle as `clr` is dropped.
- R10: At most one word is accepted per clock, and sixteen back-to-back writes fill a block in sixteen cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous discard of the block being gathered |
| in_valid | input | 1 | Host word present |
| in_ready | output | 1 | Loader can take a word |
| in_data | input | 32 | Host word, little-endian grouping |
| dtype | input | 2 | Grouping of the host data (swap mode) |
| blk_data | output | 512 | Gathered message block, first word most significant |
| blk_valid | output | 1 | Block complete and held for the core |
| blk_ack | input | 1 | Core has taken the block |

## Verification
Two kinds of internal fault would show at the ports. A wrong word count moves `blk_valid` one or more cycles away from the sixteenth write, and it also shifts every word slot. A wrong swap path corrupts the slot of the word it handled. Both faults are visible in the first cycle that `blk_valid` is high, because the bench compares the whole block against its own model at that point. A stuck handshake or a failed clear shows within a cycle as a mismatch of `in_ready` or `blk_valid` against the model. A write leaking in while the block is held shows as `blk_data` drifting before the ack.

// File: rtl/hbl_pkg.sv
package hbl_pkg;
  typedef enum logic [1:0] {
    DT_WORD = 2'b00,
    DT_HALF = 2'b01,
    DT_BYTE = 2'b10,
    DT_BIT  = 2'b11
  } dtype_e;
endpackage

// File: rtl/hbl_word_swap.sv
module hbl_word_swap
  import hbl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  dtype_e            mode,
  output logic [WORD_W-1:0] word_out
);
  localparam int HALF_W = WORD_W / 2;
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] half_sw;
  logic [WORD_W-1:0] byte_sw;
  logic [WORD_W-1:0] bit_sw;

  assign half_sw = {word_in[HALF_W-1:0], word_in[WORD_W-1:HALF_W]};

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    assign byte_sw[gb*8 +: 8] = word_in[(NBYTES-1-gb)*8 +: 8];
  end

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
    assign bit_sw[gi] = word_in[WORD_W-1-gi];
  end

  always_comb begin
    unique case (mode)
      DT_HALF: word_out = half_sw;
      DT_BYTE: word_out = byte_sw;
      DT_BIT:  word_out = bit_sw;
      default: word_out = word_in;
    endcase
  end

  // Each swap only moves bits; the number of ones never changes (R2-R5 family)
  always_comb begin
    p_ones_kept_r2: assert ($countones(word_out) == $countones(word_in) || $isunknown(word_in));
  end
endmodule

// File: rtl/hbl_fill_ctrl.sv
module hbl_fill_ctrl #(
  parameter int WORDS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     accept,
  input  logic                     ack,
  output logic                     full,
  output logic [$clog2(WORDS)-1:0] count
);
  localparam int CNT_W = $clog2(WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      full  <= 1'b0;
    end else if (full) begin
      if (ack) full <= 1'b0;
    end else if (accept) begin
      if (count == LAST) begin
        count <= '0;
        full  <= 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);

  p_full_needs_write_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(accept) && $past(count) == LAST);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !full && count == '0);

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    full && ack |=> !full && count == '0);
endmodule

// File: rtl/hbl_block_reg.sv
module hbl_block_reg #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      shift_en,
  input  logic [WORD_W-1:0]         word_in,
  output logic [WORD_W*WORDS-1:0]   block
);
  localparam int BLK_W = WORD_W * WORDS;

  // Words enter at the low end and move up, so the first lands on top
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      block <= '0;
    end else if (shift_en) begin
      block <= {block[BLK_W-WORD_W-1:0], word_in};
    end
  end

  p_shift_in_r6: assert property (@(posedge clk) disable iff (rst)
    shift_en && !clr |=> block[WORD_W-1:0] == $past(word_in));
endmodule

// File: rtl/hash_block_loader.sv
module hash_block_loader
  import hbl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 16,
  parameter int BLK_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [1:0]        dtype,
  output logic [BLK_W-1:0]  blk_data,
  output logic              blk_valid,
  input  logic              blk_ack
);
  localparam int CNT_W = $clog2(WORDS);

  logic              accept;
  logic [WORD_W-1:0] swapped;
  logic [CNT_W-1:0]  fill_count;

  assign in_ready = ~blk_valid;
  assign accept   = in_valid & in_ready & ~clr;

  hbl_word_swap #(.WORD_W(WORD_W)) u_swap (
    .word_in  (in_data),
    .mode     (dtype_e'(dtype)),
    .word_out (swapped)
  );

  hbl_fill_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .accept (accept),
    .ack    (blk_ack),
    .full   (blk_valid),
    .count  (fill_count)
  );

  hbl_block_reg #(.WORD_W(WORD_W), .WORDS(WORDS)) u_blk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .shift_en (accept),
    .word_in  (swapped),
    .block    (blk_data)
  );

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    blk_valid && !blk_ack && !clr |=> blk_valid && $stable(blk_data));

  p_no_write_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    blk_valid |=> $stable(fill_count) || clr);
endmodule

// File: tb/hash_block_loader_tb.sv
module hash_block_loader_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_data = '0;
  logic [1:0]   dtype = '0;
  logic [511:0] blk_data;
  logic         blk_valid;
  logic         blk_ack = 1'b0;

  int errors = 0;
  int checks = 0;
  string tag = "R7";

  hash_block_loader u_dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dtype(dtype), .blk_data(blk_data), .blk_valid(blk_valid),
    .blk_ack(blk_ack)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] swap_ref(logic [31:0] d, logic [1:0] t);
    logic [31:0] r;
    case (t)
      2'b00: r = d;
      2'b01: r = {d[15:0], d[31:16]};
      2'b10: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: for (int i = 0; i < 32; i++) r[i] = d[31-i];
    endcase
    return r;
  endfunction

  // Behavioural reference
  logic [31:0]  q[$];
  logic [511:0] m_blk = '0;
  bit           m_valid = 1'b0;

  always @(posedge clk) begin
    if (rst || clr) begin
      q.delete();
      m_valid = 1'b0;
      m_blk = '0;
    end else if (m_valid) begin
      if (blk_ack) m_valid = 1'b0;
    end else if (in_valid) begin
      q.push_back(swap_ref(in_data, dtype));
      if (q.size() == 16) begin
        for (int j = 0; j < 16; j++) m_blk[511-32*j -: 32] = q[j];
        q.delete();
        m_valid = 1'b1;
      end
    end
  end

  task automatic check(bit ok, string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(blk_valid == m_valid, tag, 512'(blk_valid), 512'(m_valid));
      check(in_ready == !m_valid, "R7", 512'(in_ready), 512'(!m_valid));
      if (m_valid) check(blk_data == m_blk, tag, blk_data, m_blk);
    end
  end

  task automatic step(bit v, logic [31:0] d, logic [1:0] t, bit a, bit c);
    @(negedge clk);
    in_valid = v; in_data = d; dtype = t; blk_ack = a; clr = c;
  endtask

  task automatic idle();
    step(0, 32'h0, 2'b00, 0, 0);
  endtask

  task automatic release_blk();
    step(0, 32'h0, 2'b00, 1, 0);
    idle();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] PAT = 32'h1234_5678;
  logic [31:0] exp_top [4];

  initial begin
    exp_top[0] = 32'h1234_5678;
    exp_top[1] = 32'h5678_1234;
    exp_top[2] = 32'h7856_3412;
    exp_top[3] = 32'h1E6A_2C48;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(blk_valid == 1'b0, "R1", 512'(blk_valid), 512'(0));
    check(in_ready == 1'b1, "R1", 512'(in_ready), 512'(1));
    check(blk_data == '0, "R1", blk_data, '0);

    // R2 R3 R4 R5 with back-to-back bursts (R10)
    for (int m = 0; m < 4; m++) begin
      tag = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
      for (int k = 0; k < 16; k++) begin
        step(1, PAT, 2'(m), 0, 0);
        if (k == 15) ;
      end
      idle();
      check(blk_valid == 1'b1, "R10", 512'(blk_valid), 512'(1));
      check(blk_data[511:480] == exp_top[m], tag, 512'(blk_data[511:480]), 512'(exp_top[m]));
      check(blk_data[31:0] == exp_top[m], tag, 512'(blk_data[31:0]), 512'(exp_top[m]));
      release_blk();
    end

    // R6 word order, with gaps (R8 idle cycles store nothing)
    tag = "R6";
    for (int k = 0; k < 16; k++) begin
      step(1, 32'hA000_0000 + k, 2'b00, 0, 0);
      if (k % 3 == 0) idle();
    end
    idle();
    check(blk_data[511:480] == 32'hA000_0000, "R6", 512'(blk_data[511:480]), 512'(32'hA000_0000));
    check(blk_data[31:0] == 32'hA000_000F, "R6", 512'(blk_data[31:0]), 512'(32'hA000_000F));

    // R7 held block ignores writes until ack
    tag = "R7";
    for (int k = 0; k < 3; k++) step(1, 32'hDEAD_BEEF, 2'b11, 0, 0);
    idle();
    check(blk_data[31:0] == 32'hA000_000F, "R7", 512'(blk_data[31:0]), 512'(32'hA000_000F));
    release_blk();
    check(in_ready == 1'b1, "R7", 512'(in_ready), 512'(1));

    // R8 mixed swap modes inside one block
    tag = "R8";
    for (int k = 0; k < 16; k++) step(1, 32'h0102_0304 + 32'(k), 2'(k % 4), 0, 0);
    idle();
    check(blk_data[479:448] == 32'h0305_0102, "R8", 512'(blk_data[479:448]), 512'(32'h0305_0102));
    release_blk();

    // R9 clear drops partial block and a same-cycle write
    tag = "R9";
    for (int k = 0; k < 5; k++) step(1, 32'hBAD0_0000 + k, 2'b00, 0, 0);
    step(1, 32'hBAD0_00FF, 2'b00, 0, 1);
    idle();
    check(blk_data == '0, "R9", blk_data, '0);
    for (int k = 0; k < 16; k++) step(1, 32'hC000_0000 + k, 2'b10, 0, 0);
    idle();
    check(blk_data[511:480] == 32'h0000_00C0, "R9", 512'(blk_data[511:480]), 512'(32'h0000_00C0));
    // R9 clear also drops a completed block
    step(0, 32'h0, 2'b00, 0, 1);
    idle();
    check(blk_valid == 1'b0, "R9", 512'(blk_valid), 512'(0));
    check(in_ready == 1'b1, "R9", 512'(in_ready), 512'(1));
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule